// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes waiting in a transmit FIFO into asynchronous serial frames on one output line. It watches the FIFO's empty flag and read data. When the enables and the optional clear-to-send handshake allow it, it pops one entry and sends it as a frame. Each frame is a low start bit, then 5 to 8 data bits sent least-significant first, then an optional parity bit, then 1, 1.5 or 2 stop bits. Between frames the line rests high.

Bit timing comes from an internal tick generator running at 16 ticks per bit. Its period is a divisor made of an integer part plus a fraction in sixty-fourths of a clock. The generator restarts with every frame, so each frame is timed from its own start edge. The frame format is captured when the byte is popped. Software may therefore change the format between frames without disturbing a frame in flight. Clearing either enable in the middle of a frame lets that frame finish, and no further frame is started.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is 1 and `done_o` is 1. After reset with an empty FIFO, `busy_o` and `fifo_pop_o` are 0.
- R2: A frame starts with one bit of 0 on `txd_o`. The data bits follow, least-significant bit first. `word_len_i` selects the count: 00 sends 5 bits, 01 sends 6, 10 sends 7 and 11 sends 8. Upper bits of the byte beyond that count are not sent.
- R3: With `par_en_i`=1 and `par_stick_i`=0, exactly one parity bit follows the data. With `par_even_i`=1 the total number of ones in the data bits plus the parity bit is even; with `par_even_i`=0 it is odd. With `par_en_i`=0 no parity bit is sent.
- R4: With `par_en_i`=1 and `par_stick_i`=1, the parity bit is the inverse of `par_even_i`: 0 when `par_even_i`=1 and 1 when it is 0. With `par_en_i`=0, `par_stick_i` has no effect.
- R5: The stop period is high. `stop_sel_i` sets its length: 00 gives 16 ticks, 01 gives 24, 10 gives 32, and 11 gives 16.
- R6: Every start, data and parity bit lasts 16 ticks. Tick k of a frame falls k·`div_int_i` + floor(k·`div_frac_i`/64) clock cycles after the edge on which the start bit begins. `done_o` is 0 from that edge until the edge that ends the final stop tick, and then returns to 1.
- R7: `fifo_pop_o` is high for exactly one cycle per frame, in the cycle before the start bit begins, and only while the FIFO is non-empty and no frame is in progress.
- R8: A new frame starts only while `tx_en_i` and `uart_en_i` are both 1. Clearing either one during a frame lets that frame finish with correct timing. No later frame starts until both are 1 again.
- R9: With `cts_fc_en_i`=1, a frame starts only if `cts_i`, delayed through a two-flop synchroniser, is 1. A frame already in progress completes when `cts_i` falls. With `cts_fc_en_i`=0, `cts_i` is ignored.
- R10: `busy_o` is 1 whenever the FIFO is non-empty or a frame is in progress, and 0 otherwise.
- R11: When a byte is waiting and starting is allowed, the next start bit begins one clock after the edge that ends the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int_i | input | 32 | Integer part of the tick divisor, in clocks; must be at least 1 |
| div_frac_i | input | 6 | Fractional part of the tick divisor, in 1/64 clock |
| word_len_i | input | 2 | Data bit count select (5 to 8) |
| par_en_i | input | 1 | Send a parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| par_stick_i | input | 1 | Send a fixed parity value |
| stop_sel_i | input | 2 | Stop length select |
| tx_en_i | input | 1 | Transmit enable |
| uart_en_i | input | 1 | Block enable |
| cts_fc_en_i | input | 1 | Gate frame starts on clear-to-send |
| cts_i | input | 1 | Clear-to-send from the peer, active high, asynchronous |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| fifo_data_i | input | 8 | Transmit FIFO head entry |
| fifo_pop_o | output | 1 | Remove the FIFO head entry at this clock edge |
| txd_o | output | 1 | Serial output line |
| busy_o | output | 1 | FIFO non-empty or frame in progress |
| done_o | output | 1 | No frame in progress |

## Verification
A miscounted tick or segment counter moves the edge where `done_o` rises. The bench checks that edge against the arithmetic tick formula, so a mistake of one tick appears at the end of the first frame that contains it. A wrong bit index, shift or latched parity value corrupts a sampled bit centre within that same frame. The sweep covers every word length, parity mode and stop mode across integer and fractional divisors. A fault in the enable, handshake or pop logic appears within a few dozen cycles: either a start bit the bench does not expect, or a pop counter that differs from one per frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Frame format captured when a byte is popped
    typedef struct packed {
        logic [2:0] last_bit;   // index of the final data bit (4..7)
        logic       par_on;
        logic       par_val;
        logic [1:0] stop_mode;
    } frame_fmt_t;

endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = d_in;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign d_out = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_baudgen.sv
module uart_tx_baudgen #(
    parameter int INT_W  = 32,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } bg_t;

    bg_t bg_d, bg_q;
    logic [FRAC_W:0] frac_sum;
    logic [INT_W:0]  period;
    logic [INT_W:0]  cnt_inc;

    always_comb begin
        bg_d     = bg_q;
        tick     = 1'b0;
        frac_sum = {1'b0, bg_q.acc} + {1'b0, div_frac};
        period   = {1'b0, div_int} + {{INT_W{1'b0}}, frac_sum[FRAC_W]};
        cnt_inc  = {1'b0, bg_q.cnt} + 1'b1;
        if (!run) begin
            bg_d.cnt = '0;
            bg_d.acc = '0;
        end else if (cnt_inc == period) begin
            tick     = 1'b1;
            bg_d.cnt = '0;
            bg_d.acc = frac_sum[FRAC_W-1:0];
        end else begin
            bg_d.cnt = cnt_inc[INT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bg_q <= '0;
        else        bg_q <= bg_d;
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       can_start,
    input  logic [7:0] byte_in,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic [1:0] stop_sel,
    output logic       pop,
    output logic       run,
    output logic       idle,
    output logic       txd
);
    localparam int TCW = $clog2(2 * OS + 1);
    localparam logic [TCW-1:0] BIT_LEN  = TCW'(OS);
    localparam logic [TCW-1:0] STOP_1H  = TCW'(OS + OS / 2);
    localparam logic [TCW-1:0] STOP_2   = TCW'(2 * OS);

    typedef struct packed {
        tx_state_e  st;
        logic [TCW-1:0] tcnt;
        logic [2:0] idx;
        logic [7:0] shr;
        frame_fmt_t fmt;
        logic       txd;
    } ser_t;

    ser_t s_d, s_q;
    logic [TCW-1:0] seg_len;
    logic           seg_end;
    logic [7:0]     masked;
    logic           ones_odd;

    always_comb begin
        s_d      = s_q;
        pop      = 1'b0;
        masked   = byte_in & (8'hFF >> (2'd3 - word_len));
        ones_odd = ^masked;
        case (s_q.fmt.stop_mode)
            2'b01:   seg_len = (s_q.st == ST_STOP) ? STOP_1H : BIT_LEN;
            2'b10:   seg_len = (s_q.st == ST_STOP) ? STOP_2  : BIT_LEN;
            default: seg_len = BIT_LEN;
        endcase
        seg_end = tick && (s_q.tcnt == seg_len - 1'b1);

        if (s_q.st == ST_IDLE) begin
            s_d.txd = 1'b1;
            if (can_start) begin
                pop               = 1'b1;
                s_d.st            = ST_START;
                s_d.txd           = 1'b0;
                s_d.tcnt          = '0;
                s_d.idx           = '0;
                s_d.shr           = masked;
                s_d.fmt.last_bit  = {1'b1, word_len};
                s_d.fmt.par_on    = par_en;
                s_d.fmt.par_val   = par_stick ? ~par_even
                                  : (par_even ? ones_odd : ~ones_odd);
                s_d.fmt.stop_mode = stop_sel;
            end
        end else if (tick) begin
            if (!seg_end) begin
                s_d.tcnt = s_q.tcnt + 1'b1;
            end else begin
                s_d.tcnt = '0;
                case (s_q.st)
                    ST_START: begin
                        s_d.st  = ST_DATA;
                        s_d.txd = s_q.shr[0];
                    end
                    ST_DATA: begin
                        if (s_q.idx == s_q.fmt.last_bit) begin
                            s_d.st  = s_q.fmt.par_on ? ST_PARITY : ST_STOP;
                            s_d.txd = s_q.fmt.par_on ? s_q.fmt.par_val : 1'b1;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                            s_d.shr = s_q.shr >> 1;
                            s_d.txd = s_q.shr[1];
                        end
                    end
                    ST_PARITY: begin
                        s_d.st  = ST_STOP;
                        s_d.txd = 1'b1;
                    end
                    default: begin
                        s_d.st  = ST_IDLE;
                        s_d.txd = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run  = (s_q.st != ST_IDLE);
    assign idle = (s_q.st == ST_IDLE);
    assign txd  = s_q.txd;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DIV_INT_W   = 32,
    parameter int DIV_FRAC_W  = 6,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_INT_W-1:0]  div_int_i,
    input  logic [DIV_FRAC_W-1:0] div_frac_i,
    input  logic [1:0]            word_len_i,
    input  logic                  par_en_i,
    input  logic                  par_even_i,
    input  logic                  par_stick_i,
    input  logic [1:0]            stop_sel_i,
    input  logic                  tx_en_i,
    input  logic                  uart_en_i,
    input  logic                  cts_fc_en_i,
    input  logic                  cts_i,
    input  logic                  fifo_empty_i,
    input  logic [7:0]            fifo_data_i,
    output logic                  fifo_pop_o,
    output logic                  txd_o,
    output logic                  busy_o,
    output logic                  done_o
);
    logic cts_sync;
    logic tick;
    logic run;
    logic idle;
    logic can_start;

    uart_tx_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cts_i),
        .d_out (cts_sync)
    );

    uart_tx_baudgen #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_int  (div_int_i),
        .div_frac (div_frac_i),
        .tick     (tick)
    );

    assign can_start = !fifo_empty_i && tx_en_i && uart_en_i
                     && (!cts_fc_en_i || cts_sync);

    uart_tx_serializer #(.OS(OVERSAMPLE)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .can_start (can_start),
        .byte_in   (fifo_data_i),
        .word_len  (word_len_i),
        .par_en    (par_en_i),
        .par_even  (par_even_i),
        .par_stick (par_stick_i),
        .stop_sel  (stop_sel_i),
        .pop       (fifo_pop_o),
        .run       (run),
        .idle      (idle),
        .txd       (txd_o)
    );

    assign busy_o = !fifo_empty_i || !idle;
    assign done_o = idle;
endmodule

// File: rtl/uart_frame_tx_checker.sv
module uart_frame_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en_i,
    input logic uart_en_i,
    input logic cts_fc_en_i,
    input logic cts_i,
    input logic fifo_empty_i,
    input logic fifo_pop_o,
    input logic txd_o,
    input logic done_o
);
    // R1: line rests high between frames
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> txd_o);

    // R7: pop only from idle with data present
    a_r7_pop_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (done_o && !fifo_empty_i));

    // R7: a pop is followed by the start bit
    a_r7_pop_then_start: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> (!txd_o && !done_o));

    // R6: a frame begins only through a pop
    a_r6_frame_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(fifo_pop_o));

    // R8: both enables needed to start
    a_r8_enables_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (tx_en_i && uart_en_i));

    // R9: handshake seen two samples earlier
    a_r9_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop_o && cts_fc_en_i) |-> $past(cts_i, 2));
endmodule

bind uart_frame_tx uart_frame_tx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en_i      (tx_en_i),
    .uart_en_i    (uart_en_i),
    .cts_fc_en_i  (cts_fc_en_i),
    .cts_i        (cts_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .txd_o        (txd_o),
    .done_o       (done_o)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div_int = 32'd2;
    logic [5:0]  div_frac = 6'd0;
    logic [1:0]  word_len = 2'd3;
    logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic [1:0]  stop_sel = 2'd0;
    logic        tx_en = 1'b1, uart_en = 1'b1, cts_fc_en = 1'b0, cts = 1'b0;
    logic        fifo_empty, fifo_pop, txd, busy, done;
    logic [7:0]  fifo_data;

    logic [7:0]  fmem [16];
    logic [3:0]  wr = '0;
    logic [3:0]  rd = '0;
    int          pops = 0;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    assign fifo_empty = (wr == rd);
    assign fifo_data  = fmem[rd];

    always @(posedge clk) if (fifo_pop) begin
        rd   <= rd + 1'b1;
        pops <= pops + 1;
    end

    uart_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .div_int_i(div_int), .div_frac_i(div_frac),
        .word_len_i(word_len), .par_en_i(par_en), .par_even_i(par_even),
        .par_stick_i(par_stick), .stop_sel_i(stop_sel), .tx_en_i(tx_en),
        .uart_en_i(uart_en), .cts_fc_en_i(cts_fc_en), .cts_i(cts),
        .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
        .txd_o(txd), .busy_o(busy), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic int tk(input int k);
        return k * int'(div_int) + (k * int'(div_frac)) / 64;
    endfunction

    task automatic push(input logic [7:0] b);
        fmem[wr] = b;
        wr = wr + 1'b1;
    endtask

    // Decode one frame from its start edge, checking bit centres and length
    task automatic check_frame(input logic [7:0] b);
        int nb, nseg, cum, tot, p0, waited, ones;
        int bits [12];
        int lens [12];
        int st [12];
        int en [12];
        string tags [12];
        logic [7:0] mb;
        nb   = 5 + int'(word_len);
        mb   = b & (8'hFF >> (8 - nb));
        ones = $countones(mb);
        bits[0] = 0; lens[0] = 16; tags[0] = "R2 start";
        for (int i = 0; i < nb; i++) begin
            bits[1+i] = int'(mb[i]); lens[1+i] = 16; tags[1+i] = "R2 data";
        end
        nseg = 1 + nb;
        if (par_en) begin
            if (par_stick) begin
                bits[nseg] = par_even ? 0 : 1; tags[nseg] = "R4 stick parity";
            end else begin
                bits[nseg] = par_even ? (ones % 2) : 1 - (ones % 2);
                tags[nseg] = "R3 parity";
            end
            lens[nseg] = 16;
            nseg++;
        end
        bits[nseg] = 1; tags[nseg] = "R5 stop";
        lens[nseg] = (stop_sel == 2'b01) ? 24 : (stop_sel == 2'b10) ? 32 : 16;
        nseg++;
        cum = 0;
        for (int n = 0; n < nseg; n++) begin
            st[n] = tk(cum); cum += lens[n]; en[n] = tk(cum);
        end
        tot = en[nseg-1];
        p0  = (txd === 1'b0) ? pops - 1 : pops;
        waited = 0;
        while (txd !== 1'b0 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 5000) begin
            chk(1'b0, "R2 frame never started", 0, 1);
            return;
        end
        chk(busy === 1'b1, "R10 busy during frame", int'(busy), 1);
        for (int m = 0; m <= tot; m++) begin
            for (int n = 0; n < nseg; n++)
                if (m == (st[n] + en[n]) / 2)
                    chk(int'(txd) == bits[n], tags[n], int'(txd), bits[n]);
            if (m == tot - 1) chk(done === 1'b0, "R6 frame still running", int'(done), 0);
            if (m == tot)     chk(done === 1'b1, "R6 frame ends on time", int'(done), 1);
            if (m < tot) @(negedge clk);
        end
        chk(pops == p0 + 1, "R7 one pop per frame", pops - p0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
        chk(done === 1'b1, "R1 reset done", int'(done), 1);
        chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        chk(fifo_pop === 1'b0, "R1 reset pop", int'(fifo_pop), 0);

        // Sweep: word length x parity mode x stop mode, varied divisors
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 6; pm++)
                for (int sm = 0; sm < 4; sm++) begin
                    int idx;
                    idx = wl * 24 + pm * 4 + sm;
                    div_int  = 32'(1 + idx % 3);
                    div_frac = ((idx / 3) % 3 == 0) ? 6'd0 : ((idx / 3) % 3 == 1) ? 6'd21 : 6'd63;
                    word_len = 2'(wl);
                    stop_sel = 2'(sm);
                    par_en    = (pm >= 1 && pm <= 4);
                    par_even  = (pm == 2 || pm == 3 || pm == 5);
                    par_stick = (pm >= 3);
                    push(8'(idx * 37 + 8'h5A));
                    check_frame(8'(idx * 37 + 8'h5A));
                    @(negedge clk);
                end

        div_int = 32'd2; div_frac = 6'd13; word_len = 2'd3;
        par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0; stop_sel = 2'd1;

        // R8: each enable blocks a start; R10 busy with data pending
        for (int w = 0; w < 2; w++) begin
            if (w == 0) tx_en = 1'b0; else uart_en = 1'b0;
            p0 = pops;
            push(8'h3C);
            repeat (40) @(negedge clk);
            chk(pops == p0, "R8 no start while disabled", pops - p0, 0);
            chk(txd === 1'b1, "R8 line idle while disabled", int'(txd), 1);
            chk(busy === 1'b1, "R10 busy with pending byte", int'(busy), 1);
            tx_en = 1'b1; uart_en = 1'b1;
            check_frame(8'h3C);
            @(negedge clk);
        end

        // R8: disable mid-frame, frame completes, next one held
        for (int w = 0; w < 2; w++) begin
            push(8'hC3);
            push(8'h96);
            fork
                check_frame(8'hC3);
                begin
                    repeat (50) @(negedge clk);
                    if (w == 0) uart_en = 1'b0; else tx_en = 1'b0;
                end
            join
            p0 = pops;
            repeat (60) @(negedge clk);
            chk(pops == p0, "R8 no new frame after mid-frame disable", pops - p0, 0);
            chk(done === 1'b1, "R8 idle after disable", int'(done), 1);
            chk(busy === 1'b1, "R10 busy with byte left", int'(busy), 1);
            uart_en = 1'b1; tx_en = 1'b1;
            check_frame(8'h96);
            @(negedge clk);
        end

        // R11: back-to-back frames with a one-clock gap
        stop_sel = 2'd0; par_en = 1'b0;
        push(8'h11);
        push(8'hEE);
        check_frame(8'h11);
        @(negedge clk);
        chk(txd === 1'b0, "R11 next start one clock after end", int'(txd), 0);
        check_frame(8'hEE);
        @(negedge clk);

        // R9: clear-to-send gating
        cts_fc_en = 1'b1; cts = 1'b0;
        p0 = pops;
        push(8'h5B);
        repeat (40) @(negedge clk);
        chk(pops == p0, "R9 held while cts low", pops - p0, 0);
        chk(txd === 1'b1, "R9 line idle while cts low", int'(txd), 1);
        cts = 1'b1;
        fork
            check_frame(8'h5B);
            begin
                repeat (40) @(negedge clk);
                cts = 1'b0;
            end
        join
        @(negedge clk);
        p0 = pops;
        push(8'hA4);
        repeat (40) @(negedge clk);
        chk(pops == p0, "R9 held again while cts low", pops - p0, 0);
        cts_fc_en = 1'b0;
        check_frame(8'hA4);
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R10 not busy when drained", int'(busy), 0);
        chk(txd === 1'b1, "R1 idle line after drain", int'(txd), 1);

        summary();
        $finish;
    end
endmodule